// File: doc/BRIEF.md
# Transmit Frequency Offset Rotator with DAC Output Select

This block moves an I/Q baseband transmit stream away from zero frequency by a programmable offset, so that the spectrum sits centred in its channel. Each accepted sample takes the current phase from a wrapping phase accumulator and is rotated by that angle in an iterative CORDIC engine. The accumulator then steps by the offset word. The real part of the rotated sample is corrected for CORDIC gain, clamped to the DAC width and presented as the DAC word.

Three operating modes are selected by a two-bit mode input. The double-sideband mode treats the stream as real and ignores the quadrature input. The single-sideband mode uses the quadrature input, which an upstream Hilbert stage supplies. The bypass mode ignores the rotator entirely and drives the DAC every clock with positive or negative full scale, chosen by a single bit, for fast two-level signalling. A separate sign output repeats the sign bit of the DAC word after a programmable number of DAC words. This lets polar-modulation test equipment line up with the analog reconstruction delay.

The rotator is a three-state machine. IDLE waits for a sample. On accept (the start transition) it moves to ROTATE, which runs one micro-rotation per clock for sixteen clocks. The last iteration leads to SCALE, which hands the result to the output stage and returns to IDLE.

Top module: `tx_freq_shift`

## Requirements
- R1: After reset `dac_data` is 0, `dac_valid` is 0 and `sign_out` is 0, and the first sample accepted after reset is rotated by phase 0.
- R2: For an accepted sample with inputs I and Q and accumulator value P, `dac_data` (two's complement) equals round(I·cos θ − Q·sin θ), with θ = 2π·P[23:8]/65536, within ±3 LSB unless clamped.
- R3: Mode encoding: 2'b00 is double sideband, where `in_q` is ignored and treated as zero; 2'b01 is single sideband, where `in_q` is used; any mode with bit 1 set is bypass.
- R4: The state machine goes IDLE → ROTATE (16 clocks) → SCALE → IDLE. A sample accepted at clock edge k gives exactly one `dac_valid` pulse, one clock long, following edge k+17.
- R5: `in_valid` is accepted only in IDLE outside bypass. A sample offered while ROTATE or SCALE is active produces no result and leaves the accumulator unchanged.
- R6: Results above 2047 give 2047 (0x7FF), and results below −2048 give −2048 (0x800).
- R7: In bypass, `dac_valid` is 1 on every clock. `dac_data` is 0x7FF when `bypass_bit` was 1 at the previous edge and 0x800 when it was 0. `in_valid` is ignored and the accumulator holds its value.
- R8: `sign_out` equals bit 11 of the DAC word issued D words earlier, where D = `sign_dly` (0 to 63). D = 0 gives the bit 11 of the word currently on `dac_data`.
- R9: The phase accumulator is 24 bits wide and wraps modulo 2^24. At each accept edge it adds the `freq_word` present at that edge. The sample accepted at that edge uses the value before the add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_i | input | 12 | In-phase sample, two's complement |
| in_q | input | 12 | Quadrature sample, two's complement |
| freq_word | input | 24 | Phase step per accepted sample |
| mode | input | 2 | 00 double sideband, 01 single sideband, 1x bypass |
| bypass_bit | input | 1 | Level bit used in bypass |
| sign_dly | input | 6 | Sign tap delay in DAC words |
| dac_data | output | 12 | DAC word, two's complement |
| dac_valid | output | 1 | New DAC word loaded |
| sign_out | output | 1 | Delayed sign of the DAC word |

## Verification
Phase-zero samples separate rotation errors from plain data-path errors. Quarter-turn steps in single-sideband mode check the quadrant pre-rotation and the sign of each cross term. An irregular offset word that wraps the accumulator exercises the fine CORDIC iterations and the modulo arithmetic. A nonzero quadrature input in double-sideband mode shows whether the mode gating works. Samples offered while the engine is busy, and during bypass, show whether the accumulator is kept frozen. Bypass runs with an irregular bit pattern are checked against the sign tap at delays 0, 5 and 63.

// File: rtl/tx_fs_pkg.sv
package tx_fs_pkg;

    // Angle scale for the rotator: 2^ANG_BITS units per full turn
    localparam int ANG_BITS = 20;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_ROTATE,
        CS_SCALE
    } cordic_state_e;

    localparam logic [1:0] MODE_DSB = 2'b00;
    localparam logic [1:0] MODE_SSB = 2'b01;

    // atan(2^-idx) expressed in 2^ANG_BITS units per turn
    function automatic int cordic_atan(input int idx);
        case (idx)
            0:       return 131072;
            1:       return 77376;
            2:       return 40884;
            3:       return 20753;
            4:       return 10417;
            5:       return 5213;
            6:       return 2607;
            7:       return 1304;
            8:       return 652;
            9:       return 326;
            10:      return 163;
            11:      return 81;
            12:      return 41;
            13:      return 20;
            14:      return 10;
            15:      return 5;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/tx_fs_phase_acc.sv
module tx_fs_phase_acc #(
    parameter int ACC_W = 24,
    parameter int PH_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [ACC_W-1:0] step,
    output logic [PH_W-1:0]  phase
);

    logic [ACC_W-1:0] acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (advance) begin
            acc <= acc + step;
        end
    end

    assign phase = acc[ACC_W-1 -: PH_W];

endmodule

// File: rtl/tx_fs_cordic.sv
module tx_fs_cordic
    import tx_fs_pkg::*;
#(
    parameter int DW    = 12,
    parameter int PH_W  = 16,
    parameter int ITER  = 16,
    parameter int GUARD = 2,
    parameter int FRAC  = 4,
    parameter int XW    = DW + GUARD + FRAC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [DW-1:0]        in_i,
    input  logic [DW-1:0]        in_q,
    input  logic [PH_W-1:0]      phase,
    output logic                 busy,
    output logic                 res_valid,
    output logic signed [XW-1:0] res_x
);

    localparam int ZW   = ANG_BITS + 1;
    localparam int IT_W = $clog2(ITER);

    cordic_state_e state, state_nx;

    logic signed [XW-1:0] x, y, px, py, xi, yi;
    logic signed [ZW-1:0] z, z0, atan_z;
    logic [IT_W-1:0]      it;

    assign xi = {{GUARD{in_i[DW-1]}}, in_i, {FRAC{1'b0}}};
    assign yi = {{GUARD{in_q[DW-1]}}, in_q, {FRAC{1'b0}}};

    // Quadrant pre-rotation by a multiple of 90 degrees
    always_comb begin
        case (phase[PH_W-1 -: 2])
            2'd0:    begin px = xi;  py = yi;  end
            2'd1:    begin px = -yi; py = xi;  end
            2'd2:    begin px = -xi; py = -yi; end
            default: begin px = yi;  py = -xi; end
        endcase
    end

    assign z0     = {{(ZW - ANG_BITS + 2){1'b0}}, phase[PH_W-3:0], {(ANG_BITS - PH_W){1'b0}}};
    assign atan_z = ZW'(cordic_atan(int'(it)));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CS_IDLE:   if (start) state_nx = CS_ROTATE;
            CS_ROTATE: if (it == IT_W'(ITER - 1)) state_nx = CS_SCALE;
            CS_SCALE:  state_nx = CS_IDLE;
            default:   state_nx = CS_IDLE;
        endcase
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x  <= '0;
            y  <= '0;
            z  <= '0;
            it <= '0;
        end else begin
            case (state)
                CS_IDLE: begin
                    if (start) begin
                        x  <= px;
                        y  <= py;
                        z  <= z0;
                        it <= '0;
                    end
                end
                CS_ROTATE: begin
                    if (!z[ZW-1]) begin
                        x <= x - (y >>> it);
                        y <= y + (x >>> it);
                        z <= z - atan_z;
                    end else begin
                        x <= x + (y >>> it);
                        y <= y - (x >>> it);
                        z <= z + atan_z;
                    end
                    it <= it + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy      = (state != CS_IDLE);
        res_valid = (state == CS_SCALE);
        res_x     = x;
    end

    AST_SCALE_AFTER_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CS_SCALE) |-> ($past(state) == CS_ROTATE))
        else $error("scale entered from wrong state"); // R4

    AST_SINGLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid)
        else $error("result strobe longer than one cycle"); // R4

endmodule

// File: rtl/tx_fs_out_stage.sv
module tx_fs_out_stage #(
    parameter int DW       = 12,
    parameter int XW       = 18,
    parameter int FRAC     = 4,
    parameter int GAIN_Q   = 15,
    parameter int GAIN_INV = 19899,
    parameter int DLY_W    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 res_valid,
    input  logic signed [XW-1:0] res_x,
    input  logic                 bypass_en,
    input  logic                 bypass_bit,
    input  logic [DLY_W-1:0]     sign_dly,
    output logic [DW-1:0]        dac_data,
    output logic                 dac_valid,
    output logic                 sign_out
);

    localparam int PW    = XW + GAIN_Q + 2;
    localparam int SH    = GAIN_Q + FRAC;
    localparam int DLY_N = 2 ** DLY_W - 1;

    localparam logic signed [PW-1:0] GAIN_S = PW'(GAIN_INV);
    localparam logic signed [PW-1:0] RND    = {{(PW - SH){1'b0}}, 1'b1, {(SH - 1){1'b0}}};
    localparam logic signed [PW-1:0] SAT_HI = PW'(2 ** (DW - 1) - 1);
    localparam logic signed [PW-1:0] SAT_LO = PW'(-(2 ** (DW - 1)));
    localparam logic [DW-1:0] WORD_POS = {1'b0, {(DW - 1){1'b1}}};
    localparam logic [DW-1:0] WORD_NEG = {1'b1, {(DW - 1){1'b0}}};

    logic signed [PW-1:0] prod, scaled;
    logic [DW-1:0]        sat_word, word_nx;
    logic                 load;
    logic [DLY_N-1:0]     sr;

    assign prod   = PW'(res_x) * GAIN_S;
    assign scaled = (prod + RND) >>> SH;

    always_comb begin
        if (scaled > SAT_HI)      sat_word = WORD_POS;
        else if (scaled < SAT_LO) sat_word = WORD_NEG;
        else                      sat_word = scaled[DW-1:0];
    end

    assign load    = bypass_en | res_valid;
    assign word_nx = bypass_en ? (bypass_bit ? WORD_POS : WORD_NEG) : sat_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_data  <= '0;
            dac_valid <= 1'b0;
            sr        <= '0;
        end else begin
            dac_valid <= load;
            if (load) begin
                dac_data <= word_nx;
                sr       <= {sr[DLY_N-2:0], dac_data[DW-1]};
            end
        end
    end

    assign sign_out = (sign_dly == '0) ? dac_data[DW-1] : sr[sign_dly - DLY_W'(1)];

    AST_BYPASS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_en |=> dac_valid && (dac_data == ($past(bypass_bit) ? WORD_POS : WORD_NEG)))
        else $error("bypass word wrong"); // R7

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !bypass_en && (scaled > SAT_HI)) |=> (dac_data == WORD_POS))
        else $error("positive clamp missing"); // R6

    AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !bypass_en && (scaled < SAT_LO)) |=> (dac_data == WORD_NEG))
        else $error("negative clamp missing"); // R6

endmodule

// File: rtl/tx_freq_shift.sv
module tx_freq_shift
    import tx_fs_pkg::*;
#(
    parameter int DW     = 12,
    parameter int ACC_W  = 24,
    parameter int PH_W   = 16,
    parameter int ITER   = 16,
    parameter int GUARD  = 2,
    parameter int FRAC   = 4,
    parameter int DLY_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_i,
    input  logic [DW-1:0]    in_q,
    input  logic [ACC_W-1:0] freq_word,
    input  logic [1:0]       mode,
    input  logic             bypass_bit,
    input  logic [DLY_W-1:0] sign_dly,
    output logic [DW-1:0]    dac_data,
    output logic             dac_valid,
    output logic             sign_out
);

    localparam int XW = DW + GUARD + FRAC;

    logic              busy, accept, res_valid, bypass_en;
    logic [PH_W-1:0]   phase;
    logic [DW-1:0]     q_eff;
    logic signed [XW-1:0] res_x;

    assign bypass_en = mode[1];
    assign accept    = in_valid & ~busy & ~bypass_en;
    assign q_eff     = (mode == MODE_SSB) ? in_q : '0;

    tx_fs_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (accept),
        .step    (freq_word),
        .phase   (phase)
    );

    tx_fs_cordic #(
        .DW(DW), .PH_W(PH_W), .ITER(ITER), .GUARD(GUARD), .FRAC(FRAC), .XW(XW)
    ) u_cordic (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .in_i      (in_i),
        .in_q      (q_eff),
        .phase     (phase),
        .busy      (busy),
        .res_valid (res_valid),
        .res_x     (res_x)
    );

    tx_fs_out_stage #(
        .DW(DW), .XW(XW), .FRAC(FRAC), .DLY_W(DLY_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .res_valid  (res_valid),
        .res_x      (res_x),
        .bypass_en  (bypass_en),
        .bypass_bit (bypass_bit),
        .sign_dly   (sign_dly),
        .dac_data   (dac_data),
        .dac_valid  (dac_valid),
        .sign_out   (sign_out)
    );

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(phase))
        else $error("phase moved without an accepted sample"); // R5

endmodule

// File: tb/tx_freq_shift_test.sv
module tx_freq_shift_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_i = '0;
    logic [11:0] in_q = '0;
    logic [23:0] freq_word = '0;
    logic [1:0]  mode = 2'b00;
    logic        bypass_bit = 1'b0;
    logic [5:0]  sign_dly = '0;
    logic [11:0] dac_data;
    logic        dac_valid;
    logic        sign_out;

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;
    int acc_m = 0;
    bit mon_en = 1'b1;
    bit done = 1'b0;

    int    due_q[$];
    int    val_q[$];
    string tag_q[$];
    int    hb[0:127];

    localparam real PI = 3.14159265358979;

    tx_freq_shift uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .freq_word(freq_word), .mode(mode), .bypass_bit(bypass_bit), .sign_dly(sign_dly),
        .dac_data(dac_data), .dac_valid(dac_valid), .sign_out(sign_out)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int expect_word(input int i, input int q, input int md, input int acc);
        real th, v;
        int  r;
        th = 2.0 * PI * real'(acc >> 8) / 65536.0;
        v  = real'(i) * $cos(th) - ((md == 1) ? real'(q) : 0.0) * $sin(th);
        r  = $rtoi($floor(v + 0.5));
        if (r > 2047)  r = 2047;
        if (r < -2048) r = -2048;
        return r;
    endfunction

    // Driver: offers one sample, predicts its result, waits for the engine
    task automatic send(input int i, input int q, input int fw, input int md, input string tag);
        int k;
        @(negedge clk);
        in_valid  = 1'b1;
        in_i      = 12'(i);
        in_q      = 12'(q);
        freq_word = 24'(fw);
        mode      = 2'(md);
        @(posedge clk);
        #1;
        k = cyc;
        due_q.push_back(k + 17);
        val_q.push_back(expect_word(i, q, md, acc_m));
        tag_q.push_back(tag);
        acc_m = (acc_m + fw) & 24'hFFFFFF;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (19) @(posedge clk);
    endtask

    task automatic set_phase(input int target);
        send(0, 0, (target - acc_m) & 24'hFFFFFF, 0, "R9");
    endtask

    // Monitor: compares each produced word against the scoreboard
    always @(negedge clk) begin
        if (mon_en && dac_valid && rst_n) begin
            if (due_q.size() == 0) begin
                check(1'b0, "R5 unexpected result", int'($signed(dac_data)), 0);
            end else begin
                int d, v, a;
                string t;
                d = due_q.pop_front();
                v = val_q.pop_front();
                t = tag_q.pop_front();
                a = int'($signed(dac_data));
                check(cyc == d, "R4 latency", cyc, d);
                check((a - v <= 3) && (v - a <= 3), t, a, v);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(dac_data == 12'd0, "R1 reset dac_data", int'(dac_data), 0);
        check(dac_valid == 1'b0, "R1 reset dac_valid", int'(dac_valid), 0);
        check(sign_out == 1'b0, "R1 reset sign_out", int'(sign_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1, R3: phase zero, quadrature ignored in double sideband
        send(1000, 777, 0, 0, "R1/R3 dsb phase0");
        send(-1500, -900, 0, 0, "R3 dsb q ignored");
        // R2: quarter-turn steps in single sideband
        send(1000, 500, 24'h400000, 1, "R2 ssb 0deg");
        send(1000, 500, 24'h400000, 1, "R2 ssb 90deg");
        send(1000, 500, 24'h400000, 1, "R2 ssb 180deg");
        send(1000, 500, 24'h400000, 1, "R2 ssb 270deg");

        // R5: second strobe while the engine is busy is dropped
        @(negedge clk);
        in_valid = 1'b1; in_i = 12'd600; in_q = 12'd0; freq_word = 24'h123456; mode = 2'b00;
        @(posedge clk);
        #1;
        due_q.push_back(cyc + 17);
        val_q.push_back(expect_word(600, 0, 0, acc_m));
        tag_q.push_back("R5 first sample");
        acc_m = (acc_m + 24'h123456) & 24'hFFFFFF;
        @(negedge clk); in_valid = 1'b0;
        repeat (4) @(negedge clk);
        in_valid = 1'b1; in_i = 12'd1900; freq_word = 24'h7FFFFF;
        @(negedge clk); in_valid = 1'b0;
        repeat (20) @(posedge clk);
        send(1200, 0, 0, 0, "R5 phase not advanced");

        // R2, R9: irregular offset, wrap of the accumulator
        for (int n = 0; n < 8; n++) begin
            send(300 + n * 211, -700 + n * 157, 24'h13579B, n % 2, "R2/R9 irregular offset");
        end
        for (int n = 0; n < 4; n++) begin
            send(1800 - n * 500, 400, 24'hFFF000 - n * 24'h2345, 1, "R9 wrap");
        end

        // R6: clamp at -45 degrees
        set_phase(24'hE00000);
        send(2047, 2047, 0, 1, "R6 clamp high");
        send(-2048, -2048, 0, 1, "R6 clamp low");

        // R7, R8: bypass with irregular level pattern and three tap delays
        @(negedge clk);
        mon_en = 1'b0;
        mode = 2'b10;
        for (int k = 0; k < 100; k++) begin
            int d, b;
            d = (k < 10) ? 0 : ((k < 30) ? 5 : 63);
            b = (((k * 7) >> 2) & 1) ^ ((k % 3 == 0) ? 1 : 0);
            hb[k] = b;
            bypass_bit = b[0];
            sign_dly   = 6'(d);
            in_valid   = (k % 7 == 3);
            freq_word  = 24'h111111;
            @(posedge clk);
            #1;
            check(dac_valid == 1'b1, "R7 bypass valid", int'(dac_valid), 1);
            check(dac_data == (b != 0 ? 12'h7FF : 12'h800), "R7 bypass word",
                  int'(dac_data), b != 0 ? 2047 : 2048);
            if (k >= d) begin
                check(sign_out == (hb[k - d] == 0), "R8 sign tap", int'(sign_out),
                      (hb[k - d] == 0) ? 1 : 0);
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        mode = 2'b00;
        @(posedge clk);
        #1;
        check(dac_valid == 1'b0, "R7 bypass exit", int'(dac_valid), 0);
        mon_en = 1'b1;
        // R7: accumulator frozen through bypass
        send(1500, 0, 0, 0, "R7 phase frozen in bypass");

        repeat (5) @(posedge clk);
        check(due_q.size() == 0, "R4 missing result", due_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule